// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers thirty-two interrupt inputs and turns them into two request lines toward a processor: a fast request and a normal request. Input 0 feeds only the fast line. Inputs 1 to 31 compete for the normal line. Each input has its own enable bit, a sensitivity choice (edge or level), a polarity choice, a 3-bit priority level and a 32-bit vector.

Software talks to the block over a simple word-addressed register port. A read of the current-vector address returns the vector of the winning normal input and, unless protect mode is on, also acknowledges it. The acknowledge pushes the winner's level onto a small stack, clears that input's edge latch and silences the normal line until a strictly higher level is pending. A write to the end-of-service address pops the stack, so service can nest. A routing mask can move any normal input onto the fast line, and a global mask bit forces both lines low without losing any state.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset both request outputs are low, all enables are clear (read of 0x41 gives 0), every source is configured level-sensitive, active-high, level 0, and a read of 0x40 gives 0.
- R2: Writing ones to 0x41 sets enable bits and writing ones to 0x42 clears them; a disabled source never raises a request, even while its input is active.
- R3: Source 0, when enabled and active, raises only the fast output and never becomes the normal winner.
- R4: Among enabled normal sources that are pending, the one with the highest level wins and ties go to the lower source number; a read of 0x40 returns the winner's vector (written at 0x20+n) or 0 when none is pending.
- R5: The config word at 0x00+n holds the level in bits [2:0], edge mode in bit 3 (1 = edge, 0 = level) and polarity in bit 4 (1 = rising/high, 0 = falling/low); an edge source becomes pending on the configured transition and stays pending after the input returns.
- R6: Outside protect mode a read of 0x40 while the normal output is high pushes the winner's level, clears its edge latch, and holds the normal output low until a source with a strictly higher level is pending.
- R7: A higher-level source raises the normal output while a lower one is in service; a write to 0x45 pops one level, after which the older or lower level can request again. The stack holds up to 8 levels.
- R8: With bit 0 of 0x47 set, reads of 0x40 return the vector but change no state: the normal output stays as it was.
- R9: A normal source whose bit is set in the routing mask at 0x46 raises the fast output instead of the normal one.
- R10: With bit 1 of 0x47 set, both outputs are low; clearing it restores the outputs from the untouched pending and in-service state.
- R11: Writing ones to 0x43 makes the selected sources pending; writing ones to 0x44 clears those latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Raw interrupt inputs, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| fast_req_o | output | 1 | Fast interrupt request, active high |
| norm_req_o | output | 1 | Normal interrupt request, active high |

## Verification
The hardest state to reach is a two-deep nest: a low-level source acknowledged, then a higher one arriving, acknowledged, and the stack unwound one write at a time while the inputs still hold. The bench reaches it by driving level-sensitive inputs it controls directly, acknowledging by vector reads, and checking the normal output after each read, each input change and each end-of-service write, so every push and pop shows at the pin. Edge latches are reached with single-cycle pulses and with software forcing, which also shows latch clearing by acknowledge.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int LVL_W = 3;

  typedef struct packed {
    logic             act_high;
    logic             edge_mode;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  localparam logic [7:0] A_VEC   = 8'h40;
  localparam logic [7:0] A_ENSET = 8'h41;
  localparam logic [7:0] A_ENCLR = 8'h42;
  localparam logic [7:0] A_FSET  = 8'h43;
  localparam logic [7:0] A_FCLR  = 8'h44;
  localparam logic [7:0] A_EOS   = 8'h45;
  localparam logic [7:0] A_ROUTE = 8'h46;
  localparam logic [7:0] A_CTRL  = 8'h47;

  // A candidate may request only above the level now in service.
  function automatic logic lvl_above(logic has_top, logic [LVL_W-1:0] cand,
                                     logic [LVL_W-1:0] top);
    return !has_top || (cand > top);
  endfunction

  // Active level of a raw input under the chosen polarity.
  function automatic logic lvl_on(logic raw, logic act_high);
    return act_high ? raw : !raw;
  endfunction
endpackage

// File: rtl/vpic_src_cond.sv
module vpic_src_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic edge_mode_i,
  input  logic act_high_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  import vpic_pkg::*;

  logic prev_q, lat_q, edge_hit;

  assign edge_hit = edge_mode_i &&
                    (act_high_i ? (raw_i && !prev_q) : (!raw_i && prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= raw_i;
      if (clr_i)                lat_q <= 1'b0;
      else if (edge_hit || set_i) lat_q <= 1'b1;
    end
  end

  assign pend_o = lat_q || (!edge_mode_i && lvl_on(raw_i, act_high_i));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int NSRC = 32,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]                      cand_i,
  input  logic [NSRC-1:0][vpic_pkg::LVL_W-1:0] lvl_i,
  output logic                                 valid_o,
  output logic [IDXW-1:0]                      idx_o,
  output logic [vpic_pkg::LVL_W-1:0]           lvl_o
);
  // Ascending scan with strict compare: equal levels keep the lower index.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (!valid_o || lvl_i[i] > lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDXW'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/vpic_lvl_stack.sv
module vpic_lvl_stack #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic [vpic_pkg::LVL_W-1:0]    lvl_i,
  output logic                          has_top_o,
  output logic [vpic_pkg::LVL_W-1:0]    top_lvl_o,
  output logic [CW-1:0]                 depth_o
);
  logic [vpic_pkg::LVL_W-1:0] stk_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_m1;
  logic [PW-1:0] wr_ptr, top_ptr;

  assign cnt_m1  = cnt_q - CW'(1);
  assign top_ptr = cnt_m1[PW-1:0];
  assign wr_ptr  = cnt_q[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && cnt_q < CW'(DEPTH)) begin
      stk_q[wr_ptr] <= lvl_i;
      cnt_q         <= cnt_q + CW'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_m1;
    end
  end

  assign has_top_o = (cnt_q != '0);
  assign top_lvl_o = has_top_o ? stk_q[top_ptr] : '0;
  assign depth_o   = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CW'(DEPTH));
  p_push_grows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> cnt_q == $past(cnt_q) + CW'(1));
  p_pop_shrinks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDXW  = $clog2(NSRC),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fast_req_o,
  output logic              norm_req_o
);
  import vpic_pkg::*;

  src_cfg_t          cfg_q [NSRC];
  logic [DATA_W-1:0] vec_q [NSRC];
  logic [NSRC-1:0]   en_q, route_q;
  logic              prot_q, gmask_q;

  logic [NSRC-1:0]            pend, active, cand, set_v, clr_v, ack_v;
  logic [NSRC-1:0][LVL_W-1:0] lvls;
  logic                       sel_valid, has_top, norm_raw, fast_raw;
  logic [IDXW-1:0]            sel_idx;
  logic [LVL_W-1:0]           sel_lvl, top_lvl;
  logic [CW-1:0]              stk_depth;
  logic                       vec_rd, ack_evt, eos_evt;

  // Named bus events
  assign vec_rd  = bus_rd_i && bus_addr_i == A_VEC;
  assign ack_evt = vec_rd && !prot_q && norm_raw;
  assign eos_evt = bus_wr_i && bus_addr_i == A_EOS;

  assign set_v = (bus_wr_i && bus_addr_i == A_FSET) ? bus_wdata_i[NSRC-1:0] : '0;
  assign ack_v = ack_evt ? (NSRC'(1) << sel_idx) : '0;
  assign clr_v = ((bus_wr_i && bus_addr_i == A_FCLR) ? bus_wdata_i[NSRC-1:0] : '0) | ack_v;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vpic_src_cond u_cond (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .raw_i       (src_i[g]),
      .edge_mode_i (cfg_q[g].edge_mode),
      .act_high_i  (cfg_q[g].act_high),
      .set_i       (set_v[g]),
      .clr_i       (clr_v[g]),
      .pend_o      (pend[g])
    );
    assign lvls[g] = cfg_q[g].lvl;
  end

  assign active   = pend & en_q;
  assign cand     = active & ~{route_q[NSRC-1:1], 1'b1};
  assign fast_raw = active[0] || |(active[NSRC-1:1] & route_q[NSRC-1:1]);

  vpic_arbiter #(.NSRC(NSRC)) u_arb (
    .cand_i  (cand),
    .lvl_i   (lvls),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .lvl_o   (sel_lvl)
  );

  vpic_lvl_stack #(.DEPTH(DEPTH)) u_stk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ack_evt),
    .pop_i     (eos_evt),
    .lvl_i     (sel_lvl),
    .has_top_o (has_top),
    .top_lvl_o (top_lvl),
    .depth_o   (stk_depth)
  );

  assign norm_raw   = sel_valid && lvl_above(has_top, sel_lvl, top_lvl);
  assign norm_req_o = norm_raw && !gmask_q;
  assign fast_req_o = fast_raw && !gmask_q;

  // Register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
      prot_q  <= 1'b0;
      gmask_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        cfg_q[i] <= '{act_high: 1'b1, edge_mode: 1'b0, lvl: '0};
        vec_q[i] <= '0;
      end
    end else if (bus_wr_i) begin
      if (bus_addr_i[7:5] == 3'b000)
        cfg_q[bus_addr_i[IDXW-1:0]] <= src_cfg_t'(bus_wdata_i[LVL_W+1:0]);
      else if (bus_addr_i[7:5] == 3'b001)
        vec_q[bus_addr_i[IDXW-1:0]] <= bus_wdata_i;
      else begin
        case (bus_addr_i)
          A_ENSET: en_q    <= en_q | bus_wdata_i[NSRC-1:0];
          A_ENCLR: en_q    <= en_q & ~bus_wdata_i[NSRC-1:0];
          A_ROUTE: route_q <= bus_wdata_i[NSRC-1:0];
          A_CTRL: begin
            prot_q  <= bus_wdata_i[0];
            gmask_q <= bus_wdata_i[1];
          end
          default: ;
        endcase
      end
    end
  end

  // Register reads
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_VEC:   bus_rdata_o = sel_valid ? vec_q[sel_idx] : '0;
      A_ENSET: bus_rdata_o = DATA_W'(en_q);
      A_ROUTE: bus_rdata_o = DATA_W'(route_q);
      A_CTRL:  bus_rdata_o = DATA_W'({gmask_q, prot_q});
      default: ;
    endcase
  end

  p_gmask_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_q |-> (!fast_req_o && !norm_req_o));
  p_prot_keeps_depth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && prot_q && !eos_evt) |=> stk_depth == $past(stk_depth));
  p_winner_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid |-> (pend[sel_idx] && en_q[sel_idx]));
  p_src0_not_normal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid |-> sel_idx != '0);
  p_src0_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[0] && en_q[0] && !gmask_q) |-> fast_req_o);
endmodule

// File: tb/vpic_ctrl_tb.sv
module vpic_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fast, norm;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vpic_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fast_req_o(fast), .norm_req_o(norm)
  );

  // Arbitration table: {src a, level a, src b, level b, expected winner}
  localparam logic [20:0] ARB_TBL [6] = '{
    {5'd3,  3'd2, 5'd7,  3'd5, 5'd7},
    {5'd9,  3'd4, 5'd4,  3'd4, 5'd4},
    {5'd31, 3'd7, 5'd1,  3'd6, 5'd31},
    {5'd5,  3'd0, 5'd6,  3'd0, 5'd5},
    {5'd12, 3'd1, 5'd12, 3'd1, 5'd12},
    {5'd2,  3'd3, 5'd30, 3'd3, 5'd2}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic drive(int n, logic v);
    @(negedge clk); src[n] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fast", 32'(fast), 0);
    chk("R1 norm", 32'(norm), 0);
    rreg(8'h40, v); chk("R1 vector", v, 0);
    rreg(8'h41, v); chk("R1 enables", v, 0);

    for (int n = 0; n < 32; n++) wreg(8'h20 + 8'(n), 32'h1000 + 32'(n));
    src[4] = 1'b1;
    wreg(8'h04, 32'h12);
    @(negedge clk); chk("R2 disabled", 32'(norm), 0);
    src[4] = 1'b0;
    wreg(8'h41, 32'hFFFF_FFFF);

    // R4 arbitration table, protect mode so reads have no side effects
    wreg(8'h47, 32'h1);
    for (int k = 0; k < 6; k++) begin
      logic [20:0] e;
      e = ARB_TBL[k];
      wreg({3'b000, e[20:16]}, 32'h10 | 32'(e[15:13]));
      wreg({3'b000, e[12:8]},  32'h10 | 32'(e[7:5]));
      @(negedge clk); src[e[20:16]] = 1'b1; src[e[12:8]] = 1'b1;
      @(negedge clk); chk("R4 norm", 32'(norm), 1);
      rreg(8'h40, v); chk("R4 winner vector", v, 32'h1000 + 32'(e[4:0]));
      src = '0;
    end
    rreg(8'h40, v); chk("R4 none pending", v, 0);

    // R6/R7 nesting
    wreg(8'h47, 32'h0);
    wreg(8'h04, 32'h12);
    wreg(8'h09, 32'h15);
    drive(4, 1'b1); chk("R7 low level request", 32'(norm), 1);
    rreg(8'h40, v); chk("R6 ack vector", v, 32'h1004);
    chk("R6 silenced after ack", 32'(norm), 0);
    drive(9, 1'b1); chk("R7 higher preempts", 32'(norm), 1);
    rreg(8'h40, v); chk("R7 nested vector", v, 32'h1009);
    chk("R6 silenced nested", 32'(norm), 0);
    wreg(8'h45, 0); chk("R7 pop re-requests higher", 32'(norm), 1);
    drive(9, 1'b0); chk("R7 equal level blocked", 32'(norm), 0);
    wreg(8'h45, 0); chk("R7 pop to empty", 32'(norm), 1);
    drive(4, 1'b0); chk("R7 idle", 32'(norm), 0);

    // R8 protect mode
    wreg(8'h47, 32'h1);
    drive(4, 1'b1);
    rreg(8'h40, v); chk("R8 vector", v, 32'h1004);
    chk("R8 norm kept", 32'(norm), 1);
    rreg(8'h40, v); chk("R8 repeat read", v, 32'h1004);
    drive(4, 1'b0);
    wreg(8'h47, 32'h0);

    // R5 edge modes, R6 latch clear by ack
    wreg(8'h06, 32'h19);
    @(negedge clk); src[6] = 1'b1;
    @(negedge clk); src[6] = 1'b0;
    @(negedge clk); chk("R5 rising edge held", 32'(norm), 1);
    rreg(8'h40, v); chk("R5 edge vector", v, 32'h1006);
    wreg(8'h45, 0); chk("R6 latch cleared by ack", 32'(norm), 0);
    wreg(8'h08, 32'h0B);
    drive(8, 1'b1); chk("R5 rising ignored on falling cfg", 32'(norm), 0);
    drive(8, 1'b0); @(negedge clk); chk("R5 falling edge", 32'(norm), 1);
    wreg(8'h44, 32'h100); chk("R11 force clear", 32'(norm), 0);
    wreg(8'h43, 32'h40); chk("R11 force set", 32'(norm), 1);
    rreg(8'h40, v); chk("R11 forced vector", v, 32'h1006);
    wreg(8'h45, 0);
    wreg(8'h43, 32'h40);
    wreg(8'h44, 32'h40); chk("R11 force then clear", 32'(norm), 0);

    // R5 level low polarity
    wreg(8'h0D, 32'h02); @(negedge clk); chk("R5 low level active", 32'(norm), 1);
    drive(13, 1'b1); chk("R5 low level inactive", 32'(norm), 0);
    wreg(8'h0D, 32'h10); src[13] = 1'b0;

    // R9 routing, R3 source 0
    wreg(8'h46, 32'h400);
    drive(10, 1'b1); chk("R9 routed fast", 32'(fast), 1);
    chk("R9 routed not normal", 32'(norm), 0);
    drive(10, 1'b0);
    drive(0, 1'b1); chk("R3 src0 fast", 32'(fast), 1);
    chk("R3 src0 not normal", 32'(norm), 0);

    // R10 global mask
    drive(4, 1'b1);
    wreg(8'h47, 32'h2);
    chk("R10 fast masked", 32'(fast), 0);
    chk("R10 norm masked", 32'(norm), 0);
    wreg(8'h47, 32'h0);
    chk("R10 fast restored", 32'(fast), 1);
    chk("R10 norm restored", 32'(norm), 1);
    drive(0, 1'b0); chk("R3 src0 released", 32'(fast), 0);

    // R2 enable clear/set
    wreg(8'h42, 32'h10); chk("R2 cleared", 32'(norm), 0);
    wreg(8'h41, 32'h10); chk("R2 set", 32'(norm), 1);
    drive(4, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule